// File: doc/BRIEF.md
# DDR2 Write Burst Scheduler

This block sits on the controller side of a DDR2-style memory interface. It turns a stream of write requests into WRITE commands and correctly timed write-data bursts. Each request carries a bank, a column, four data words, four mask bits and a burst-order select, and is offered on a ready/valid handshake. An accepted request becomes a WRITE on the command bus in the next cycle. Every other cycle carries a NOP.

The write latency is WL = AL + CL - 1. WL clock cycles after a WRITE, the block drives a four-beat burst on a double-rate data path. The path is modelled as a rising-half and a falling-half beat per clock, so one burst covers two clocks. The burst starts at the element named by the two low column bits and follows either sequential or interleaved order. The mask moves with its data word.

Requests may arrive faster than the column-to-column spacing tCCD allows. In that case the block holds off the requester, so WRITEs are never closer than tCCD. When WRITEs sit exactly tCCD apart, their bursts join into one unbroken data and strobe window. Wider spacing leaves idle, undriven cycles between bursts.

Top module: `wr_burst_sched`

## Requirements
- R1: The first beat pair of a burst appears exactly WL = AL + CL - 1 clock cycles after the cycle in which its WRITE is on the command bus.
- R2: A request accepted at a clock edge (req_valid and req_ready both high) puts cmd_write=1 with that bank and column on the command bus in the following cycle. In a cycle with no acceptance at the previous edge, a NOP is issued: cmd_write=0 with bank and column zero.
- R3: After an accepted request, req_ready stays low for TCCD-1 cycles, so no two WRITEs are fewer than TCCD cycles apart.
- R4: A burst has four beats. Beats 0 and 1 appear on dq_rise and dq_fall in the first burst cycle, and beats 2 and 3 appear in the second burst cycle.
- R5: With req_ilv=0 (sequential order), with s = req_col[1:0], beat i carries word (s+i) mod 4. Word k is req_data[k*DQ_W +: DQ_W].
- R6: With req_ilv=1 (interleaved order), beat i carries word s XOR i. The order select is taken at acceptance.
- R7: The mask bit for a beat is req_mask[k] of the word k that the beat carries. It appears on dm_rise/dm_fall in the same cycle and half as that word.
- R8: Two WRITEs exactly TCCD cycles apart produce bursts with no idle cycle between them: dq_oe and dqs_en stay high across the join.
- R9: In any cycle outside a burst, dq_oe is low and dq_rise, dq_fall, dm_rise and dm_fall are zero.
- R10: dqs_en is high in exactly the cycles that carry burst beats.
- R11: While reset is asserted, req_ready is high, cmd_write is 0, and dq_oe and dqs_en are low.
- R12: Each WRITE may target any bank, including one different from or the same as the previous WRITE, with no effect on timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request offered |
| req_ready | output | 1 | Request can be accepted at this edge |
| req_bank | input | BANK_W | Target bank |
| req_col | input | COL_W | Target column; bits [1:0] pick the starting word |
| req_data | input | 4*DQ_W | Four data words, word k at [k*DQ_W +: DQ_W] |
| req_mask | input | 4 | Mask bit k belongs to word k |
| req_ilv | input | 1 | 0 = sequential order, 1 = interleaved order |
| cmd_write | output | 1 | 1 = WRITE, 0 = NOP |
| cmd_bank | output | BANK_W | Bank of the WRITE |
| cmd_col | output | COL_W | Column of the WRITE |
| dq_rise | output | DQ_W | Data beat for the rising half |
| dq_fall | output | DQ_W | Data beat for the falling half |
| dm_rise | output | 1 | Mask for the rising-half beat |
| dm_fall | output | 1 | Mask for the falling-half beat |
| dq_oe | output | 1 | Data and mask are driven |
| dqs_en | output | 1 | Strobe enable for the burst window |

## Verification
The bench builds the block with AL=1 and CL=3, which gives a write latency of three cycles rather than two, so the latency must come from the additive formula and not from a fixed offset. It uses TCCD=2 and 8-bit data words. With this spacing, a requester that holds valid high exercises the stall and the gapless join of several bursts. Single writes with long gaps exercise the idle cycles. The column start values and both burst orders are covered, including the wrap of sequential order and the swap pattern of interleaved order.

// File: rtl/wbs_pkg.sv
package wbs_pkg;

  typedef enum logic {
    ORD_SEQ   = 1'b0,
    ORD_INTLV = 1'b1
  } burst_order_e;

  localparam int BEATS = 4;

  // Source word index for beat idx of a burst starting at word start.
  function automatic logic [1:0] beat_src(input logic [1:0] start,
                                          input logic [1:0] idx,
                                          input burst_order_e mode);
    if (mode == ORD_INTLV) return start ^ idx;
    else                   return start + idx;
  endfunction

endpackage

// File: rtl/wbs_cmd_gate.sv
module wbs_cmd_gate #(
  parameter int TCCD = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  output logic req_ready,
  output logic accept
);

  localparam int CW = (TCCD > 1) ? $clog2(TCCD) : 1;
  localparam logic [CW-1:0] HOLD = CW'(TCCD - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign req_ready = (cnt_q == '0);
  assign accept    = req_valid && req_ready;

  always_comb begin
    cnt_d = cnt_q;
    if (accept)              cnt_d = HOLD;
    else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/wbs_beat_order.sv
module wbs_beat_order
  import wbs_pkg::*;
#(
  parameter int DQ_W = 16
) (
  input  logic [BEATS*DQ_W-1:0] data_in,
  input  logic [BEATS-1:0]      mask_in,
  input  logic [1:0]            start,
  input  burst_order_e          mode,
  output logic [BEATS*DQ_W-1:0] data_out,
  output logic [BEATS-1:0]      mask_out
);

  for (genvar g = 0; g < BEATS; g++) begin : g_beat
    localparam logic [1:0] IDX = 2'(g);
    logic [1:0] src;
    assign src = beat_src(start, IDX, mode);
    assign data_out[g*DQ_W +: DQ_W] = data_in[src*DQ_W +: DQ_W];
    assign mask_out[g]              = mask_in[src];
  end

endmodule

// File: rtl/wbs_data_pipe.sv
module wbs_data_pipe
  import wbs_pkg::*;
#(
  parameter int DQ_W = 16,
  parameter int WL   = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [BEATS*DQ_W-1:0] load_data,
  input  logic [BEATS-1:0]      load_mask,
  output logic [DQ_W-1:0]       dq_rise,
  output logic [DQ_W-1:0]       dq_fall,
  output logic                  dm_rise,
  output logic                  dm_fall,
  output logic                  dq_oe,
  output logic                  dqs_en
);

  localparam int LAST = WL + 1;

  // Stage k holds a burst k cycles after its WRITE cycle.
  logic [LAST:0]             vld_q, vld_d;
  logic [BEATS*DQ_W-1:0]     dat_q [0:LAST];
  logic [BEATS-1:0]          msk_q [0:LAST];
  logic                      head, tail;

  assign vld_d = {vld_q[LAST-1:0], load};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  // Datapath without reset; gated by stage valid bits.
  always_ff @(posedge clk) begin
    if (load) begin
      dat_q[0] <= load_data;
      msk_q[0] <= load_mask;
    end
    for (int k = 1; k <= LAST; k++) begin
      if (vld_q[k-1]) begin
        dat_q[k] <= dat_q[k-1];
        msk_q[k] <= msk_q[k-1];
      end
    end
  end

  assign head = vld_q[WL];
  assign tail = vld_q[LAST];

  always_comb begin
    dq_rise = '0;
    dq_fall = '0;
    dm_rise = 1'b0;
    dm_fall = 1'b0;
    if (head) begin
      dq_rise = dat_q[WL][0*DQ_W +: DQ_W];
      dq_fall = dat_q[WL][1*DQ_W +: DQ_W];
      dm_rise = msk_q[WL][0];
      dm_fall = msk_q[WL][1];
    end else if (tail) begin
      dq_rise = dat_q[LAST][2*DQ_W +: DQ_W];
      dq_fall = dat_q[LAST][3*DQ_W +: DQ_W];
      dm_rise = msk_q[LAST][2];
      dm_fall = msk_q[LAST][3];
    end
  end

  assign dq_oe  = head || tail;
  assign dqs_en = head || tail;

endmodule

// File: rtl/wr_burst_sched.sv
module wr_burst_sched
  import wbs_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int COL_W  = 10,
  parameter int DQ_W   = 16,
  parameter int AL     = 0,
  parameter int CL     = 3,
  parameter int TCCD   = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [BANK_W-1:0]     req_bank,
  input  logic [COL_W-1:0]      req_col,
  input  logic [4*DQ_W-1:0]     req_data,
  input  logic [3:0]            req_mask,
  input  logic                  req_ilv,
  output logic                  cmd_write,
  output logic [BANK_W-1:0]     cmd_bank,
  output logic [COL_W-1:0]      cmd_col,
  output logic [DQ_W-1:0]       dq_rise,
  output logic [DQ_W-1:0]       dq_fall,
  output logic                  dm_rise,
  output logic                  dm_fall,
  output logic                  dq_oe,
  output logic                  dqs_en
);

  localparam int WL = AL + CL - 1;

  logic                  accept;
  logic [4*DQ_W-1:0]     ord_data;
  logic [3:0]            ord_mask;
  burst_order_e          ord_mode;

  logic                  wr_q, wr_d;
  logic [BANK_W-1:0]     bank_q, bank_d;
  logic [COL_W-1:0]      col_q, col_d;

  assign ord_mode = req_ilv ? ORD_INTLV : ORD_SEQ;

  wbs_cmd_gate #(.TCCD(TCCD)) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .accept    (accept)
  );

  wbs_beat_order #(.DQ_W(DQ_W)) u_order (
    .data_in  (req_data),
    .mask_in  (req_mask),
    .start    (req_col[1:0]),
    .mode     (ord_mode),
    .data_out (ord_data),
    .mask_out (ord_mask)
  );

  // Command bus: WRITE on acceptance, NOP with zero address otherwise.
  always_comb begin
    wr_d   = accept;
    bank_d = accept ? req_bank : '0;
    col_d  = accept ? req_col  : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      bank_q <= '0;
      col_q  <= '0;
    end else begin
      wr_q   <= wr_d;
      bank_q <= bank_d;
      col_q  <= col_d;
    end
  end

  assign cmd_write = wr_q;
  assign cmd_bank  = bank_q;
  assign cmd_col   = col_q;

  wbs_data_pipe #(.DQ_W(DQ_W), .WL(WL)) u_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_data (ord_data),
    .load_mask (ord_mask),
    .dq_rise   (dq_rise),
    .dq_fall   (dq_fall),
    .dm_rise   (dm_rise),
    .dm_fall   (dm_fall),
    .dq_oe     (dq_oe),
    .dqs_en    (dqs_en)
  );

endmodule

// File: rtl/wr_burst_sched_chk.sv
module wr_burst_sched_chk #(
  parameter int WL   = 2,
  parameter int TCCD = 2,
  parameter int DQ_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            cmd_write,
  input logic [DQ_W-1:0] dq_rise,
  input logic [DQ_W-1:0] dq_fall,
  input logic            dm_rise,
  input logic            dm_fall,
  input logic            dq_oe,
  input logic            dqs_en
);

  logic [WL:0] hist;
  logic [15:0] since;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist  <= '0;
      since <= 16'(TCCD);
    end else begin
      hist <= {hist[WL-1:0], cmd_write};
      if (cmd_write)              since <= 16'd1;
      else if (since < 16'(TCCD)) since <= since + 16'd1;
    end
  end

  AST_ACCEPT_GIVES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> cmd_write); // R2

  AST_IDLE_GIVES_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> !cmd_write); // R2

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R3

  AST_WRITE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_write |-> (since >= 16'(TCCD))); // R3

  AST_STROBE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    dqs_en == (hist[WL-1] || hist[WL])); // R10

  AST_DATA_AT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    hist[WL-1] |-> dq_oe); // R1

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> (dq_rise == '0 && dq_fall == '0 && !dm_rise && !dm_fall)); // R9

endmodule

bind wr_burst_sched wr_burst_sched_chk #(.WL(WL), .TCCD(TCCD), .DQ_W(DQ_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .cmd_write (cmd_write),
  .dq_rise   (dq_rise),
  .dq_fall   (dq_fall),
  .dm_rise   (dm_rise),
  .dm_fall   (dm_fall),
  .dq_oe     (dq_oe),
  .dqs_en    (dqs_en)
);

// File: tb/wr_burst_sched_bench.sv
module wr_burst_sched_bench;

  localparam int BANK_W = 3;
  localparam int COL_W  = 10;
  localparam int DQ_W   = 8;
  localparam int AL     = 1;
  localparam int CL     = 3;
  localparam int TCCD   = 2;
  localparam int WL     = AL + CL - 1;

  logic              clk;
  logic              rst_n;
  logic              req_valid;
  logic              req_ready;
  logic [BANK_W-1:0] req_bank;
  logic [COL_W-1:0]  req_col;
  logic [4*DQ_W-1:0] req_data;
  logic [3:0]        req_mask;
  logic              req_ilv;
  logic              cmd_write;
  logic [BANK_W-1:0] cmd_bank;
  logic [COL_W-1:0]  cmd_col;
  logic [DQ_W-1:0]   dq_rise, dq_fall;
  logic              dm_rise, dm_fall, dq_oe, dqs_en;

  wr_burst_sched #(
    .BANK_W(BANK_W), .COL_W(COL_W), .DQ_W(DQ_W),
    .AL(AL), .CL(CL), .TCCD(TCCD)
  ) u_wr_burst_sched (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_bank(req_bank), .req_col(req_col), .req_data(req_data),
    .req_mask(req_mask), .req_ilv(req_ilv),
    .cmd_write(cmd_write), .cmd_bank(cmd_bank), .cmd_col(cmd_col),
    .dq_rise(dq_rise), .dq_fall(dq_fall), .dm_rise(dm_rise), .dm_fall(dm_fall),
    .dq_oe(dq_oe), .dqs_en(dqs_en)
  );

  typedef struct {
    int                tag;
    logic [BANK_W-1:0] bank;
    logic [COL_W-1:0]  col;
  } cexp_t;

  typedef struct {
    int              tag;
    logic [DQ_W-1:0] r;
    logic [DQ_W-1:0] f;
    logic            mr;
    logic            mf;
    string           rq;
  } dexp_t;

  cexp_t cq[$];
  dexp_t dq[$];

  int cyc = 0;
  int n_vec = 0;
  int n_bad = 0;
  int last_wr = -100;
  bit running = 0;
  bit done = 0;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s at cycle %0d: actual 0x%0h expected 0x%0h", rq, what, cyc, act, exp);
    end
  endtask

  function automatic logic [1:0] src_of(input logic [1:0] s, input int i, input bit ilv);
    return ilv ? (s ^ 2'(i)) : 2'(s + 2'(i));
  endfunction

  task automatic send(input logic [BANK_W-1:0] b, input logic [COL_W-1:0] c,
                      input logic [4*DQ_W-1:0] d, input logic [3:0] m,
                      input bit ilv, input int gap, input string rq);
    cexp_t ce;
    dexp_t d0, d1;
    logic [1:0] s;
    req_valid = 1'b1;
    req_bank  = b;
    req_col   = c;
    req_data  = d;
    req_mask  = m;
    req_ilv   = ilv;
    while (!req_ready) @(negedge clk);
    s = c[1:0];
    ce.tag = cyc + 1; ce.bank = b; ce.col = c;
    cq.push_back(ce);
    d0.tag = cyc + 1 + WL;
    d0.r  = d[src_of(s, 0, ilv)*DQ_W +: DQ_W];
    d0.f  = d[src_of(s, 1, ilv)*DQ_W +: DQ_W];
    d0.mr = m[src_of(s, 0, ilv)];
    d0.mf = m[src_of(s, 1, ilv)];
    d0.rq = {"R1 ", rq};
    d1.tag = cyc + 2 + WL;
    d1.r  = d[src_of(s, 2, ilv)*DQ_W +: DQ_W];
    d1.f  = d[src_of(s, 3, ilv)*DQ_W +: DQ_W];
    d1.mr = m[src_of(s, 2, ilv)];
    d1.mf = m[src_of(s, 3, ilv)];
    d1.rq = {"R4 ", rq};
    dq.push_back(d0);
    dq.push_back(d1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R3", "ready after accept", req_ready, 0);
    repeat (gap) @(negedge clk);
  endtask

  // Monitor: compares outputs against the scoreboard each cycle.
  always @(negedge clk) begin
    if (running && rst_n) begin
      if (cq.size() > 0 && cq[0].tag == cyc) begin
        cexp_t e;
        e = cq.pop_front();
        chk(cmd_write == 1'b1, "R2", "cmd_write", cmd_write, 1);
        chk(cmd_bank == e.bank, "R12", "cmd_bank", cmd_bank, e.bank);
        chk(cmd_col == e.col, "R2", "cmd_col", cmd_col, e.col);
        chk(cyc - last_wr >= TCCD, "R3", "write spacing", cyc - last_wr, TCCD);
        last_wr = cyc;
      end else begin
        chk(cmd_write == 1'b0 && cmd_bank == '0 && cmd_col == '0, "R2", "nop",
            {cmd_write, cmd_bank, cmd_col}, 0);
      end
      if (dq.size() > 0 && dq[0].tag == cyc) begin
        dexp_t e;
        e = dq.pop_front();
        chk(dq_oe == 1'b1, "R8", "dq_oe in burst", dq_oe, 1);
        chk(dqs_en == 1'b1, "R10", "dqs_en in burst", dqs_en, 1);
        chk(dq_rise == e.r, e.rq, "dq_rise", dq_rise, e.r);
        chk(dq_fall == e.f, e.rq, "dq_fall", dq_fall, e.f);
        chk({dm_rise, dm_fall} == {e.mr, e.mf}, "R7", "mask", {dm_rise, dm_fall}, {e.mr, e.mf});
      end else begin
        chk(!dq_oe && dq_rise == '0 && dq_fall == '0 && !dm_rise && !dm_fall, "R9",
            "idle data", {dq_oe, dq_rise, dq_fall, dm_rise, dm_fall}, 0);
        chk(dqs_en == 1'b0, "R10", "dqs_en idle", dqs_en, 0);
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired at cycle %0d: actual 0 expected 1", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_bank = '0;
    req_col = '0;
    req_data = '0;
    req_mask = '0;
    req_ilv = 1'b0;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R11", "ready in reset", req_ready, 1);
    chk(cmd_write == 1'b0, "R11", "cmd in reset", cmd_write, 0);
    chk(!dq_oe && !dqs_en, "R11", "oe in reset", {dq_oe, dqs_en}, 0);
    rst_n = 1'b1;
    running = 1'b1;
    @(negedge clk);

    // Single bursts, sequential start 0, interleaved start 3, sequential start 2.
    send(3'd1, 10'h010, 32'h44_33_22_11, 4'b0000, 1'b0, 8, "R5");
    send(3'd5, 10'h07B, 32'hD4_C3_B2_A1, 4'b0010, 1'b1, 8, "R6");
    send(3'd2, 10'h102, 32'h0F_0E_0D_0C, 4'b0101, 1'b0, 8, "R5 R7");
    send(3'd6, 10'h3FE, 32'h99_88_77_66, 4'b1001, 1'b1, 8, "R6 R7");

    // Gapless stream: valid held, spacing set by the stall.
    send(3'd7, 10'h001, 32'h14_13_12_11, 4'b1000, 1'b0, 0, "R8 R5");
    send(3'd0, 10'h002, 32'h24_23_22_21, 4'b0001, 1'b1, 0, "R8 R6");
    send(3'd3, 10'h003, 32'h34_33_32_31, 4'b0110, 1'b0, 0, "R8 R12");
    send(3'd3, 10'h201, 32'h44_43_42_41, 4'b1111, 1'b1, 0, "R8 R12");

    // Spaced bursts with idle cycles between them.
    send(3'd4, 10'h000, 32'h5A_A5_3C_C3, 4'b0011, 1'b0, 1, "R9");
    send(3'd1, 10'h003, 32'h01_02_04_08, 4'b1100, 1'b0, 3, "R9 R5");
    send(3'd2, 10'h001, 32'hF0_E0_D0_C0, 4'b0100, 1'b1, 2, "R9 R6");

    repeat (WL + 10) @(negedge clk);
    chk(cq.size() == 0 && dq.size() == 0, "R2", "scoreboard drained", cq.size() + dq.size(), 0);
    running = 1'b0;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule